// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filtering

This block receives asynchronous serial frames, least significant bit first, in one of two formats. The first carries eight data bits and a stop bit. The second carries eight data bits, a ninth bit and a stop bit. The line is sampled on an oversampling strobe that runs at `OVS` ticks per bit. A falling edge starts a frame. The start bit is checked again at mid-bit, and each following bit is sampled at its own mid-point.

On a shared multidrop line, a node sets the multiprocessor enable. From then on, only address frames whose byte matches one of the node's two masked addresses raise the receive flag. One of these addresses is the node's own address and the other is the broadcast address. In nine-bit mode, an address frame is one whose ninth bit is high. In eight-bit mode the stop bit serves as that marker.

A framing-error flag can be enabled. Once set, it stays set. Enabling it also moves the point at which a nine-bit frame raises the receive flag, from the ninth bit to the stop bit.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `ri_o`, `fe_o`, `data_o` and `bit9_o` are all zero.
- R2: With `nine_bit_i`=1, a frame is a low start bit, then D0..D7 (LSB first), then D8, then the stop bit. With `nine_bit_i`=0, the frame is the start bit, D0..D7, then the stop bit. `data_o` and `bit9_o` change only in the cycle in which `ri_o` is set.
- R3: With `mp_en_i`=0, every complete frame sets `ri_o` and loads `data_o`. `bit9_o` receives D8 in nine-bit mode and the sampled stop bit in eight-bit mode.
- R4: With `mp_en_i`=1 in nine-bit mode, a frame whose D8 is 0 is discarded. `ri_o` stays 0 and `data_o` keeps its value.
- R5: With `mp_en_i`=1, an address frame is accepted only when the received byte equals `own_addr_i` in every bit where `own_mask_i` is 1, or equals `bc_addr_i` in every bit where `bc_mask_i` is 1. Mask bits that are 0 are don't-care.
- R6: With `mp_en_i`=1 in eight-bit mode, an accepted frame must end with a high stop bit. A frame whose stop bit is low leaves `ri_o` at 0.
- R7: In nine-bit mode with `fe_en_i`=0, `ri_o` is set once D8 has been sampled, before the stop bit. With `fe_en_i`=1, or in eight-bit mode, `ri_o` is set only after the stop bit has been sampled.
- R8: With `fe_en_i`=1, a low stop bit sets `fe_o`. Later frames with a high stop bit leave it set, and only `fe_clr_i` clears it. With `fe_en_i`=0, `fe_o` is not set.
- R9: `ri_o` stays 1 until `ri_clr_i` is pulsed. If a frame sets `ri_o` in the same cycle, the set wins.
- R10: If the line is high again at the mid-point of the start bit, the receiver returns to idle and no frame is reported. A frame that follows is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling strobe, `OVS` pulses per bit |
| nine_bit_i | input | 1 | 1: nine-bit frame format, 0: eight-bit frame format |
| mp_en_i | input | 1 | Multiprocessor enable (address filtering) |
| fe_en_i | input | 1 | Framing-error enable; also selects the late receive point |
| own_addr_i | input | 8 | Own address |
| own_mask_i | input | 8 | Own-address compare mask, 1 = compared |
| bc_addr_i | input | 8 | Broadcast address |
| bc_mask_i | input | 8 | Broadcast compare mask, 1 = compared |
| ri_clr_i | input | 1 | Clears `ri_o` |
| fe_clr_i | input | 1 | Clears `fe_o` |
| data_o | output | 8 | Last accepted byte |
| bit9_o | output | 1 | D8, or the stop bit in eight-bit mode, of the last accepted frame |
| ri_o | output | 1 | Receive flag |
| fe_o | output | 1 | Sticky framing-error flag |

## Verification
A bit counter or sampling phase that is off by one shows up as a shifted or corrupted byte on `data_o` at the very next accepted frame. A wrong state in the frame sequencer shows up as a missing or spurious `ri_o` within one frame time. A fault in the address comparators or the mask handling shows up only at the ports, as an address frame that is wrongly accepted or wrongly dropped. The bench therefore walks matching, masked, broadcast and foreign addresses in both formats. The decision point is checked by reading `ri_o` between the D8 sample and the stop sample. This exposes a wrongly selected point within the same frame.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/mp_uart_rx_sync.sv
module mp_uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= 1'b1;
        else if (s == 0) pipe_q[s] <= d_i;
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mp_uart_rx_frame.sv
module mp_uart_rx_frame
  import mp_uart_rx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int DW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          nine_bit_i,
  output logic [DW-1:0] data_o,
  output logic          d8_o,
  output logic          last_stb_o,
  output logic          stop_stb_o,
  output logic          stop_o
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int IW   = $clog2(DW + 2);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW:0]   sh_q;
  logic          prev_q;
  logic [IW-1:0] last_idx;
  logic          bit_mid;

  assign last_idx = nine_bit_i ? IW'(DW) : IW'(DW - 1);
  assign bit_mid  = (cnt_q == CW'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      sh_q       <= '0;
      prev_q     <= 1'b1;
      last_stb_o <= 1'b0;
      stop_stb_o <= 1'b0;
      stop_o     <= 1'b0;
    end else begin
      last_stb_o <= 1'b0;
      stop_stb_o <= 1'b0;
      if (tick_i) begin
        prev_q <= rx_i;
        unique case (state_q)
          RX_IDLE: begin
            if (prev_q && !rx_i) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == CW'(HALF - 1)) begin
              cnt_q <= '0;
              idx_q <= '0;
              // false start: line back high at mid-bit
              state_q <= rx_i ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (bit_mid) begin
              cnt_q       <= '0;
              sh_q[idx_q] <= rx_i;
              if (idx_q == last_idx) begin
                state_q    <= RX_STOP;
                last_stb_o <= 1'b1;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (bit_mid) begin
              cnt_q      <= '0;
              stop_o     <= rx_i;
              stop_stb_o <= 1'b1;
              state_q    <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o = sh_q[DW-1:0];
  assign d8_o   = sh_q[DW];
endmodule

// File: rtl/mp_uart_rx_filter.sv
module mp_uart_rx_filter #(
  parameter int DW     = 8,
  parameter int N_ADDR = 2
) (
  input  logic [DW-1:0]             data_i,
  input  logic [N_ADDR-1:0][DW-1:0] addr_i,
  input  logic [N_ADDR-1:0][DW-1:0] mask_i,
  output logic                      hit_o
);
  logic [N_ADDR-1:0] hit;

  generate
    for (genvar a = 0; a < N_ADDR; a++) begin : g_cmp
      assign hit[a] = ~|((data_i ^ addr_i[a]) & mask_i[a]);
    end
  endgenerate

  assign hit_o = |hit;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int OVS      = 16,
  parameter int DW       = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxd_i,
  input  logic          tick_i,
  input  logic          nine_bit_i,
  input  logic          mp_en_i,
  input  logic          fe_en_i,
  input  logic [DW-1:0] own_addr_i,
  input  logic [DW-1:0] own_mask_i,
  input  logic [DW-1:0] bc_addr_i,
  input  logic [DW-1:0] bc_mask_i,
  input  logic          ri_clr_i,
  input  logic          fe_clr_i,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          ri_o,
  output logic          fe_o
);
  localparam int N_ADDR = 2;

  logic          rx_s;
  logic [DW-1:0] frm_data;
  logic          frm_d8;
  logic          last_stb;
  logic          stop_stb;
  logic          stop_val;
  logic          addr_hit;
  logic          late_pt;
  logic          frame_evt;
  logic          ninth;
  logic          accept;
  logic          fe_set;

  mp_uart_rx_sync #(.STAGES(SYNC_STG)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  mp_uart_rx_frame #(.OVS(OVS), .DW(DW)) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rx_i      (rx_s),
    .nine_bit_i(nine_bit_i),
    .data_o    (frm_data),
    .d8_o      (frm_d8),
    .last_stb_o(last_stb),
    .stop_stb_o(stop_stb),
    .stop_o    (stop_val)
  );

  mp_uart_rx_filter #(.DW(DW), .N_ADDR(N_ADDR)) i_filter (
    .data_i(frm_data),
    .addr_i({bc_addr_i, own_addr_i}),
    .mask_i({bc_mask_i, own_mask_i}),
    .hit_o (addr_hit)
  );

  // eight-bit frames always decide at stop; nine-bit decide at D8 unless FE checking
  assign late_pt   = !nine_bit_i || fe_en_i;
  assign frame_evt = late_pt ? stop_stb : last_stb;
  assign ninth     = nine_bit_i ? frm_d8 : stop_val;
  assign accept    = frame_evt && (!mp_en_i || (ninth && addr_hit));
  assign fe_set    = stop_stb && fe_en_i && !stop_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ri_o   <= 1'b0;
      fe_o   <= 1'b0;
      data_o <= '0;
      bit9_o <= 1'b0;
    end else begin
      if (accept) begin
        ri_o   <= 1'b1;
        data_o <= frm_data;
        bit9_o <= ninth;
      end else if (ri_clr_i) begin
        ri_o <= 1'b0;
      end
      if (fe_set) fe_o <= 1'b1;
      else if (fe_clr_i) fe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ri_o,
  input logic          fe_o,
  input logic          ri_clr_i,
  input logic          fe_clr_i,
  input logic          fe_en_i,
  input logic          mp_en_i,
  input logic          bit9_o,
  input logic [DW-1:0] data_o,
  input logic          stop_stb_i
);
  // R9
  ri_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_o && !ri_clr_i |=> ri_o);

  // R8
  fe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_o && !fe_clr_i |=> fe_o);

  // R8
  fe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fe_o) |-> $past(stop_stb_i) && $past(fe_en_i));

  // R2
  data_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != $past(data_o)) |-> ri_o);

  // R4 R6
  addr_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ri_o) && mp_en_i |-> bit9_o);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ri_o      (ri_o),
  .fe_o      (fe_o),
  .ri_clr_i  (ri_clr_i),
  .fe_clr_i  (fe_clr_i),
  .fe_en_i   (fe_en_i),
  .mp_en_i   (mp_en_i),
  .bit9_o    (bit9_o),
  .data_o    (data_o),
  .stop_stb_i(stop_stb)
);

// File: tb/test_mp_uart_rx.sv
`timescale 1ns/1ps
module test_mp_uart_rx;
  localparam int OVS = 16;
  localparam int BIT = OVS * 2; // tick every second cycle
  localparam int NV  = 12;

  // {nine, mp, fe, data[7:0], b9, stop, exp_ri, exp_fe}
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'hA4, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'hF7, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'h33, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       rxd = 1'b1;
  logic       nine_bit = 1'b0, mp_en = 1'b0, fe_en = 1'b0;
  logic [7:0] own_addr = 8'hA5, own_mask = 8'hFF;
  logic [7:0] bc_addr = 8'hF0, bc_mask = 8'hF0;
  logic       ri_clr = 1'b0, fe_clr = 1'b0;
  logic [7:0] data;
  logic       bit9, ri, fe;
  logic       peek_ri;
  logic [7:0] data_before;
  int         total = 0, bad = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else tick <= ~tick;

  mp_uart_rx i_mp_uart_rx (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick_i(tick),
    .nine_bit_i(nine_bit), .mp_en_i(mp_en), .fe_en_i(fe_en),
    .own_addr_i(own_addr), .own_mask_i(own_mask),
    .bc_addr_i(bc_addr), .bc_mask_i(bc_mask),
    .ri_clr_i(ri_clr), .fe_clr_i(fe_clr),
    .data_o(data), .bit9_o(bit9), .ri_o(ri), .fe_o(fe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stopb);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (nine_bit) drive_bit(b9);
    peek_ri = ri;
    drive_bit(stopb);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic clear_flags();
    ri_clr = 1'b1; fe_clr = 1'b1;
    @(negedge clk);
    ri_clr = 1'b0; fe_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ri", ri, 0);
    check("R1 fe", fe, 0);
    check("R1 data", data, 0);
    check("R1 bit9", bit9, 0);
    rst_n = 1'b1;
    repeat (BIT) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [14:0] e;
      e = VEC[v];
      nine_bit = e[14]; mp_en = e[13]; fe_en = e[12];
      clear_flags();
      data_before = data;
      send(e[11:4], e[3], e[2]);
      // R2 R3 R4 R5 R6 R8 vector walk
      check($sformatf("R5 vec%0d ri", v), ri, e[1]);
      check($sformatf("R8 vec%0d fe", v), fe, e[0]);
      if (e[1]) begin
        check($sformatf("R2 vec%0d data", v), data, e[11:4]);
        check($sformatf("R3 vec%0d bit9", v), bit9, e[14] ? e[3] : e[2]);
      end else begin
        check($sformatf("R4 vec%0d data kept", v), data, data_before);
      end
    end

    // R7 decision point, nine-bit
    nine_bit = 1'b1; mp_en = 1'b0; fe_en = 1'b0;
    clear_flags();
    send(8'h6E, 1'b0, 1'b1);
    check("R7 early ri", peek_ri, 1);
    clear_flags();
    fe_en = 1'b1;
    send(8'h6F, 1'b1, 1'b1);
    check("R7 late ri before stop", peek_ri, 0);
    check("R7 late ri after stop", ri, 1);

    // R8 sticky FE
    nine_bit = 1'b0; fe_en = 1'b1;
    clear_flags();
    send(8'h11, 1'b0, 1'b0);
    check("R8 fe set", fe, 1);
    ri_clr = 1'b1; @(negedge clk); ri_clr = 1'b0;
    send(8'h22, 1'b0, 1'b1);
    check("R8 fe sticky", fe, 1);
    check("R8 next data", data, 8'h22);
    fe_clr = 1'b1; @(negedge clk); fe_clr = 1'b0; @(negedge clk);
    check("R8 fe cleared", fe, 0);

    // R9 RI holds until cleared
    repeat (200) @(negedge clk);
    check("R9 ri held", ri, 1);
    ri_clr = 1'b1; @(negedge clk); ri_clr = 1'b0; @(negedge clk);
    check("R9 ri cleared", ri, 0);

    // R10 false start
    fe_en = 1'b0;
    rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (BIT * 12) @(negedge clk);
    check("R10 no frame", ri, 0);
    send(8'hC3, 1'b0, 1'b1);
    check("R10 following frame ri", ri, 1);
    check("R10 following frame data", data, 8'hC3);

    // R5 masked own address
    nine_bit = 1'b1; mp_en = 1'b1; own_addr = 8'hA0; own_mask = 8'hF0;
    clear_flags();
    send(8'hAB, 1'b1, 1'b1);
    check("R5 masked match", ri, 1);
    check("R5 masked data", data, 8'hAB);
    clear_flags();
    send(8'hBB, 1'b1, 1'b1);
    check("R5 masked miss", ri, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule